// File: doc/BRIEF.md
# SPI Burst Master with FIFO Flow Control

This block is an SPI master that moves bursts far longer than its two 64-byte FIFOs. Software loads a 24-bit byte count and sets a start bit. The shifter then exchanges that many bytes in mode 0, most significant bit first. It takes each outgoing byte from the transmit FIFO and places each incoming byte in the receive FIFO. Software reaches both FIFOs and all control state through a small register port with a 3-bit word address.

Software is paced by level-sensitive flags. One flag rises while the transmit FIFO is at or below a quarter full, so software knows to refill it. Another rises while the receive FIFO is at least three quarters full, so software knows to drain it. A third flag marks the end of the burst. Each flag is cleared by writing 1 to it. A flag whose condition still holds is set again at once. A hold mode lets a long burst survive slow software: with it on, the serial clock stops between bytes whenever the receive FIFO is full or the transmit FIFO is empty, and no byte is lost.

Register words: 0 control, 1 interrupt enable, 2 status, 3 burst count, 4 transmit data (write pushes), 5 receive data (read pops), 6 FIFO levels.

Top module: `spi_burst_master`

## Requirements
- R1: After reset both FIFO levels read 0, irq is low, sclk is low, cs_n is high, the control word reads 0, and the status word reads only bit 12 set.
- R2: Bytes are exchanged in SPI mode 0, most significant bit first. mosi is stable while sclk rises, and miso is sampled on each rising sclk edge. The received byte equals the eight sampled bits.
- R3: While shifting, sclk has a period of 2*(D+1) system clocks, where D is control bits [15:8].
- R4: Writing 1 to control bit 0 starts a burst of exactly the count held in word 3 (24 bits). Word 3 reads the bytes still to go. Bit 0 clears itself at the end of the burst, and status bit 16 is then set.
- R5: Each FIFO holds 64 bytes. A push to a full transmit FIFO is ignored. Word 6 shows the receive level in bits [6:0] and the transmit level in bits [22:16].
- R6: Status bit 4 is set while the receive level is 48 or more. Writing 1 to it clears it only once the level has fallen below 48.
- R7: Status bit 12 is set while the transmit level is 16 or less. A write-1-to-clear leaves it set when that condition still holds.
- R8: irq is high exactly when some status bit among 4, 12 and 16 is set together with the same bit in the enable word (word 1).
- R9: With hold mode on (control bit 1) and the receive FIFO full, no new byte starts and sclk stays low. Shifting resumes once space frees up, and every byte arrives intact.
- R10: With hold mode on and the transmit FIFO empty while bytes remain, sclk stays low until data is pushed. With hold mode off, an empty transmit FIFO sends 0x00 instead.
- R11: Writes to the control word and the burst count are ignored while a burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; pops the receive FIFO at word 5 |
| rdata | output | 32 | Register read data, combinational on addr |
| irq | output | 1 | Level interrupt request |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select, low while a burst runs |

## Verification
The assertions assume that software never pops the receive FIFO or pushes the transmit FIFO through any path other than the register port. They also assume that the burst count and control fields are written only while idle. The bench keeps to this by issuing all register accesses one at a time on falling clock edges and by writing the count only before setting the start bit. Hold mode is exercised in both stall directions. The serial loop feeds mosi back inverted on miso, so every received byte has a known expected value.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 64,
  parameter int CNTW  = 24,
  parameter int DIVW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = AW + 1;
  localparam int RX_HI = DEPTH * 3 / 4;
  localparam int TX_LO = DEPTH / 4;
  localparam logic [31:0] FLAGS = (32'd1 << 4) | (32'd1 << 12) | (32'd1 << 16);

  logic            go, hold;
  logic [DIVW-1:0] div;
  logic [31:0]     ien, stat;
  logic [CNTW-1:0] left;

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [FW-1:0] tx_cnt, rx_cnt;

  logic            active, sclk_r, rbit;
  logic [2:0]      bitn;
  logic [DIVW-1:0] dcnt;
  logic [7:0]      sh;

  wire tx_empty  = tx_cnt == '0;
  wire rx_full   = rx_cnt == FW'(DEPTH);
  wire tx_push   = wr_en && addr == 3'd4 && !(tx_cnt == FW'(DEPTH));
  wire rx_pop    = rd_en && addr == 3'd5 && rx_cnt != '0;
  wire can_start = go && !active && left != '0 && !(hold && (tx_empty || rx_full));
  wire tx_pop    = can_start && !tx_empty;
  wire tick      = active && dcnt == div;
  wire byte_done = tick && sclk_r && bitn == 3'd7;
  wire rx_push   = byte_done && !rx_full;
  wire done      = go && !active && left == '0;
  wire idle_wr   = wr_en && !go;
  wire [7:0]  rx_byte = {sh[6:0], rbit};
  wire [31:0] w1c     = (wr_en && addr == 3'd2) ? wdata : 32'd0;
  wire [31:0] setv    = ({31'd0, rx_cnt >= FW'(RX_HI)} << 4)
                      | ({31'd0, tx_cnt <= FW'(TX_LO)} << 12)
                      | ({31'd0, done} << 16);

  assign irq  = |(stat & ien);
  assign sclk = sclk_r;
  assign mosi = active & sh[7];
  assign cs_n = !go;

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: begin rdata[0] = go; rdata[1] = hold; rdata[8 +: DIVW] = div; end
      3'd1: rdata = ien;
      3'd2: rdata = stat;
      3'd3: rdata[CNTW-1:0] = left;
      3'd5: if (rx_cnt != '0) rdata[7:0] = rxm[rx_rp];
      3'd6: begin rdata[FW-1:0] = rx_cnt; rdata[16 +: FW] = tx_cnt; end
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= wdata[7:0];
    if (rx_push) rxm[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; hold <= 1'b0; div <= '0; ien <= '0; stat <= '0; left <= '0;
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt <= '0; rx_cnt <= '0;
    end else begin
      if (idle_wr && addr == 3'd0) begin
        go <= wdata[0]; hold <= wdata[1]; div <= wdata[8 +: DIVW];
      end else if (done) go <= 1'b0;
      if (wr_en && addr == 3'd1) ien <= wdata & FLAGS;
      stat <= ((stat & ~w1c) | setv) & FLAGS;
      if (idle_wr && addr == 3'd3) left <= wdata[CNTW-1:0];
      else if (byte_done) left <= left - 1'b1;
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + FW'(tx_push) - FW'(tx_pop);
      rx_cnt <= rx_cnt + FW'(rx_push) - FW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_r <= 1'b0; rbit <= 1'b0;
      bitn <= '0; dcnt <= '0; sh <= '0;
    end else if (can_start) begin
      sh <= tx_empty ? 8'h00 : txm[tx_rp];
      active <= 1'b1; bitn <= '0; dcnt <= '0; sclk_r <= 1'b0;
    end else if (active) begin
      if (tick) begin
        dcnt <= '0;
        if (!sclk_r) begin
          sclk_r <= 1'b1;
          rbit   <= miso;
        end else begin
          sclk_r <= 1'b0;
          sh     <= {sh[6:0], rbit};
          if (bitn == 3'd7) active <= 1'b0;
          else bitn <= bitn + 1'b1;
        end
      end else dcnt <= dcnt + 1'b1;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FW'(DEPTH) && rx_cnt <= FW'(DEPTH));
  p_hold_rx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go && hold && rx_full && !active |=> !active && !sclk_r);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !sclk_r && !active);
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go && $past(go) |-> left <= $past(left));
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[16]) |-> !go && left == '0);
  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_r) |-> $stable(mosi));
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic irq, sclk, mosi, cs_n;
  wire  miso = ~mosi;

  int nvec = 0, nbad = 0;

  spi_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((i * 37 + s * 11 + 5) & 8'hff);
  endfunction

  initial begin
    #(PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] got;
    time t0, t1;
    int pushed, drained;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(3'd6, v); check("R1 levels", v, 32'd0);
    rd(3'd0, v); check("R1 ctrl", v, 32'd0);
    rd(3'd2, v); check("R1 status", v, 32'h1000);
    check("R1 pins", {29'd0, irq, sclk, cs_n}, 32'd1);

    // R2 R3: divider sweep, MSB-first capture
    for (int d = 0; d < 4; d++) begin
      wr(3'd4, {24'd0, pat(d, 0)});
      wr(3'd3, 32'd1);
      wr(3'd0, (d << 8) | 1);
      t0 = 0; t1 = 0; got = '0;
      for (int k = 0; k < 8; k++) begin
        @(posedge sclk);
        if (k == 0) t0 = $time;
        if (k == 1) t1 = $time;
        got = {got[6:0], mosi};
      end
      check("R3 sclk period", 32'((t1 - t0) / PERIOD), 32'(2 * (d + 1)));
      check("R2 mosi msb first", {24'd0, got}, {24'd0, pat(d, 0)});
      wait_done();
      rd(3'd5, v); check("R2 rx byte", v, {24'd0, ~pat(d, 0)});
      rd(3'd2, v); check("R4 done flag", v & 32'h10000, 32'h10000);
      wr(3'd2, 32'h10000);
    end

    // R5 R7 R11: overflow push, threshold flag, busy writes ignored
    for (int i = 0; i < 65; i++) wr(3'd4, {24'd0, pat(7, i)});
    rd(3'd6, v); check("R5 tx level full", v, 32'd64 << 16);
    wr(3'd2, 32'h1000);
    rd(3'd2, v); check("R7 flag clears above quarter", v & 32'h1000, 32'd0);
    wr(3'd3, 32'd64);
    wr(3'd0, 32'h3);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R11 ctrl kept while busy", v & 32'h3, 32'h3);
    rd(3'd3, v); check("R11 count kept while busy", 32'(v > 32'd50), 32'd1);
    wait_done();
    rd(3'd6, v); check("R5 rx level 64", v, 32'd64);
    rd(3'd2, v); check("R6 rx flag", v & 32'h10, 32'h10);
    wr(3'd2, 32'h1010);
    rd(3'd2, v); check("R6 R7 flags persist", v & 32'h1010, 32'h1010);
    for (int i = 0; i < 64; i++) begin
      rd(3'd5, v); check("R5 rx data", v, {24'd0, ~pat(7, i)});
    end
    wr(3'd2, 32'h10);
    rd(3'd2, v); check("R6 rx flag clears when low", v & 32'h10, 32'd0);

    // R8 interrupt masking
    wr(3'd1, 32'h1000); @(negedge clk); check("R8 irq tx flag", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h10);   @(negedge clk); check("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h10000); @(negedge clk); check("R8 irq done", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h10000); @(negedge clk); check("R8 irq after clear", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'd0);

    // R9 hold on full rx
    for (int i = 0; i < 64; i++) wr(3'd4, {24'd0, pat(3, i)});
    wr(3'd3, 32'd70);
    wr(3'd0, 32'h3);
    repeat (1300) @(negedge clk);
    for (int i = 64; i < 70; i++) wr(3'd4, {24'd0, pat(3, i)});
    repeat (200) @(negedge clk);
    rd(3'd3, v); check("R9 stalled count", v, 32'd6);
    check("R9 sclk held", {31'd0, sclk}, 32'd0);
    rd(3'd6, v); check("R9 levels", v, (32'd6 << 16) | 32'd64);
    for (int i = 0; i < 64; i++) begin
      rd(3'd5, v); check("R9 no loss", v, {24'd0, ~pat(3, i)});
    end
    wait_done();
    for (int i = 64; i < 70; i++) begin
      rd(3'd5, v); check("R9 tail", v, {24'd0, ~pat(3, i)});
    end

    // R10 hold on empty tx, then filler without hold
    wr(3'd4, 32'h5a); wr(3'd4, 32'hc3);
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h3);
    repeat (200) @(negedge clk);
    rd(3'd3, v); check("R10 held count", v, 32'd2);
    check("R10 sclk held", {31'd0, sclk}, 32'd0);
    wr(3'd4, 32'h01); wr(3'd4, 32'hf0);
    wait_done();
    rd(3'd5, v); check("R10 b0", v, 32'ha5);
    rd(3'd5, v); check("R10 b1", v, 32'h3c);
    rd(3'd5, v); check("R10 b2", v, 32'hfe);
    rd(3'd5, v); check("R10 b3", v, 32'h0f);
    wr(3'd4, 32'h81);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h1);
    wait_done();
    rd(3'd5, v); check("R10 real byte", v, 32'h7e);
    rd(3'd5, v); check("R10 filler", v, 32'hff);

    // R4 R6 R7: 200-byte burst paced by the flags
    pushed = 0; drained = 0;
    for (int i = 0; i < 64; i++) begin wr(3'd4, {24'd0, pat(9, pushed)}); pushed++; end
    wr(3'd3, 32'd200);
    wr(3'd0, 32'h3);
    for (int it = 0; it < 5000 && drained < 200; it++) begin
      rd(3'd2, v);
      if (v[12]) begin
        while (pushed < 200) begin
          rd(3'd6, v);
          if (v[22:16] == 7'd64) break;
          wr(3'd4, {24'd0, pat(9, pushed)}); pushed++;
        end
        wr(3'd2, 32'h1000);
      end
      rd(3'd6, v);
      if (v[6:0] >= 7'd48 || (pushed == 200 && v[6:0] != 0)) begin
        for (int n = int'(v[6:0]); n > 0; n--) begin
          rd(3'd5, v);
          if (v !== {24'd0, ~pat(9, drained)})
            check("R4 long burst data", v, {24'd0, ~pat(9, drained)});
          drained++;
        end
        wr(3'd2, 32'h10);
      end
    end
    check("R4 long burst count", 32'(drained), 32'd200);
    wait_done();
    rd(3'd2, v); check("R4 long burst done", v & 32'h10000, 32'h10000);
    check("R4 cs released", {31'd0, cs_n}, 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule